// File: doc/BRIEF.md
# Doorbell Mailbox with Sender and Receiver Register Ports

This block joins two agents through a set of 32-bit doorbell channels. The sending agent owns one register port and the receiving agent owns another; both are simple synchronous buses with a 12-bit byte address, 32-bit data, a strobe and a write enable. The number of channels is a parameter. Read data returns on the clock edge after the read strobe and reads as zero in every other cycle. Each channel has its own 32-byte window on both ports.

On the sending port, software first opens the mailbox by writing 1 to the request register. It then polls the grant register until it reads nonzero, and raises flags through a channel's set register. While the mailbox is open, set writes OR bits into the flag word. On the receiving port, software reads the flags, hides chosen bits with a per-channel mask, and clears serviced bits. A level interrupt toward the receiver is high whenever any unmasked flag is pending in any channel.

Both ports carry a configuration register that reports the channel count and an architecture identifier that reports the revision. At minor revision 1 the sending port also has a small per-channel event register. It records that the receiver has fully emptied a channel.

Top module: `doorbell_mailbox`

## Requirements
- R1: After reset every flag word, every mask, the request, the grant and every sender event bit are zero, and `rx_irq` is low.
- R2: Read data appears on the port's read-data output on the edge after the read strobe. A word address that is unmapped reads zero and ignores writes. This includes a reserved offset inside a window, a window of a channel index at or above `NUM_CH`, and an unused address at 0xF80 or above.
- R3: Channel n's window begins at byte n*0x20. On the sending port, offset 0x00 reads the flag word. A write to offset 0x0C ORs the written bits into the flag word when the grant condition of R4 holds, so zero bits leave flags unchanged.
- R4: While the request register reads 0, writes to any set register leave every flag word unchanged.
- R5: Sending-port 0xF88 is the request register (bit 0, read/write). Sending-port 0xF8C is the grant register (bit 0, read-only). The grant reads 1 starting two cycles after the request first reads 1. Writing 0 to the request drops the request and the grant together on that write's edge.
- R6: On the receiving port, offset 0x00 reads the flag word and a write to offset 0x08 clears the flag bits written as 1; writing all ones empties the channel. When a set and a clear hit the same bit in one cycle, the bit ends set.
- R7: On the receiving port, offset 0x10 reads the mask, and writes to 0x14 and 0x18 set and clear the mask bits written as 1. Offset 0x04 reads the flag word AND NOT the mask. The mask resets to zero.
- R8: `rx_irq` is the OR of all unmasked flag bits over all channels. It reflects a register write from the edge of that write.
- R9: Address 0xF80 on both ports reads `NUM_CH`. Address 0xFCC on both ports reads 0x10 plus `MINOR_REV`, so the major revision 1 is in bits 7:4 and the minor revision is in bits 3:0.
- R10: At `MINOR_REV` 1, sending-port window offset 0x18 bit 0 is a read/write event enable. Offset 0x10 bit 0 becomes 1 when, with the enable set, a receiver clear takes that channel's flag word from nonzero to zero. Writing 1 to bit 0 of offset 0x14 resets it. At `MINOR_REV` 0 these offsets read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Active-low synchronous reset |
| s_en | input | 1 | Sending-port access strobe |
| s_we | input | 1 | Sending-port write enable (0 = read) |
| s_addr | input | 12 | Sending-port byte address |
| s_wdata | input | 32 | Sending-port write data |
| s_rdata | output | 32 | Sending-port read data, one cycle after the strobe |
| r_en | input | 1 | Receiving-port access strobe |
| r_we | input | 1 | Receiving-port write enable (0 = read) |
| r_addr | input | 12 | Receiving-port byte address |
| r_wdata | input | 32 | Receiving-port write data |
| r_rdata | output | 32 | Receiving-port read data, one cycle after the strobe |
| rx_irq | output | 1 | Level interrupt: some unmasked flag is pending |

## Verification
The assertions assume that each port raises its write enable only together with its strobe. They also assume that a mask-set and a mask-clear never reach one channel in the same cycle, which a single receiving port cannot produce. The grant timing properties count cycles from a request write, so they rely on the request being driven only through address 0xF88. The bench keeps to these conditions: it issues one access per port per cycle, and it issues simultaneous accesses on both ports only in the set-versus-clear case.

// File: rtl/dbm_pkg.sv
package dbm_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned IDX_W  = 7;
  typedef logic [DATA_W-1:0] word_t;

  // window offsets
  localparam logic [4:0] OFF_FLAGS   = 5'h00;
  localparam logic [4:0] OFF_VISIBLE = 5'h04;
  localparam logic [4:0] OFF_CLEAR   = 5'h08;
  localparam logic [4:0] OFF_RAISE   = 5'h0C;
  localparam logic [4:0] OFF_EVT_ST  = 5'h10;
  localparam logic [4:0] OFF_EVT_ACK = 5'h14;
  localparam logic [4:0] OFF_EVT_EN  = 5'h18;
  localparam logic [4:0] OFF_HIDE_ST = 5'h10;
  localparam logic [4:0] OFF_HIDE_ON = 5'h14;
  localparam logic [4:0] OFF_HIDE_OFF = 5'h18;

  // frame-level addresses
  localparam logic [ADDR_W-1:0] A_WIN_END = 12'hF80;
  localparam logic [ADDR_W-1:0] A_COUNT   = 12'hF80;
  localparam logic [ADDR_W-1:0] A_OPEN    = 12'hF88;
  localparam logic [ADDR_W-1:0] A_GRANT   = 12'hF8C;
  localparam logic [ADDR_W-1:0] A_ARCH    = 12'hFCC;
  localparam logic [3:0]        ARCH_MAJOR = 4'h1;

  function automatic word_t next_flags(word_t cur, logic clr_on, word_t clr,
                                       logic set_on, word_t set);
    word_t keep;
    keep = cur & ~(clr_on ? clr : '0);
    return keep | (set_on ? set : '0);
  endfunction

  function automatic word_t next_hide(word_t cur, logic on_en, word_t on_bits,
                                      logic off_en, word_t off_bits);
    word_t grown;
    grown = cur | (on_en ? on_bits : '0);
    return grown & ~(off_en ? off_bits : '0);
  endfunction

  function automatic word_t arch_word(logic [3:0] minor);
    return {{(DATA_W-8){1'b0}}, ARCH_MAJOR, minor};
  endfunction
endpackage

// File: rtl/dbm_access.sv
module dbm_access (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_val,
  output logic open_q,
  output logic grant_q
);
  logic open_nx;
  logic armed_q;

  assign open_nx = wr_en ? wr_val : open_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q  <= 1'b0;
      armed_q <= 1'b0;
      grant_q <= 1'b0;
    end else begin
      open_q  <= open_nx;
      armed_q <= open_nx & open_q;
      grant_q <= open_nx & armed_q;
    end
  end

  AST_GRANT_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    grant_q |-> open_q);                                   // R5
  AST_GRANT_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_q) |-> ($past(open_q) && $past(open_q, 2))); // R5
  AST_GRANT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(open_q) |-> !grant_q);                           // R5
endmodule

// File: rtl/dbm_channel.sv
module dbm_channel
  import dbm_pkg::*;
#(
  parameter bit HAS_EVT = 1'b1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  set_en,
  input  word_t set_bits,
  input  logic  clr_en,
  input  word_t clr_bits,
  input  logic  hide_on_en,
  input  word_t hide_on_bits,
  input  logic  hide_off_en,
  input  word_t hide_off_bits,
  input  logic  evt_en_we,
  input  logic  evt_en_val,
  input  logic  evt_ack,
  output word_t flags,
  output word_t hide,
  output word_t visible,
  output logic  evt_st,
  output logic  evt_en
);
  word_t flags_nx;
  logic  drain_evt;

  assign flags_nx  = next_flags(flags, clr_en, clr_bits, set_en, set_bits);
  assign drain_evt = clr_en && (flags != '0) && (flags_nx == '0);
  assign visible   = flags & ~hide;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags <= '0;
      hide  <= '0;
    end else begin
      flags <= flags_nx;
      hide  <= next_hide(hide, hide_on_en, hide_on_bits, hide_off_en, hide_off_bits);
    end
  end

  generate
    if (HAS_EVT) begin : g_evt
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          evt_en <= 1'b0;
          evt_st <= 1'b0;
        end else begin
          if (evt_en_we) evt_en <= evt_en_val;
          evt_st <= (evt_st & ~evt_ack) | (drain_evt & evt_en);
        end
      end
      AST_EVT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt_st) |-> $past(evt_en));                  // R10
    end else begin : g_no_evt
      assign evt_en = 1'b0;
      assign evt_st = 1'b0;
    end
  endgenerate

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !set_en) |=> ((flags & $past(clr_bits)) == '0));   // R6
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> ((flags & $past(set_bits)) == $past(set_bits)));    // R6
  AST_HIDE_ON_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (hide_on_en && !hide_off_en) |=> ((hide & $past(hide_on_bits)) == $past(hide_on_bits))); // R7
endmodule

// File: rtl/doorbell_mailbox.sv
module doorbell_mailbox
  import dbm_pkg::*;
#(
  parameter int unsigned NUM_CH    = 4,
  parameter int unsigned MINOR_REV = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        s_en,
  input  logic        s_we,
  input  logic [11:0] s_addr,
  input  logic [31:0] s_wdata,
  output logic [31:0] s_rdata,
  input  logic        r_en,
  input  logic        r_we,
  input  logic [11:0] r_addr,
  input  logic [31:0] r_wdata,
  output logic [31:0] r_rdata,
  output logic        rx_irq
);
  localparam bit    HAS_EVT = (MINOR_REV == 1);
  localparam word_t ARCH_ID = arch_word(4'(MINOR_REV));
  localparam word_t COUNT   = word_t'(NUM_CH);

  // address split
  logic [IDX_W-1:0] s_idx, r_idx;
  logic [4:0]       s_off, r_off;
  logic             s_win, r_win, s_wr, r_wr, s_rd, r_rd;

  assign s_idx = s_addr[11:5];
  assign s_off = s_addr[4:0];
  assign r_idx = r_addr[11:5];
  assign r_off = r_addr[4:0];
  assign s_win = (s_addr < A_WIN_END) && (s_idx < IDX_W'(NUM_CH));
  assign r_win = (r_addr < A_WIN_END) && (r_idx < IDX_W'(NUM_CH));
  assign s_wr  = s_en & s_we;
  assign r_wr  = r_en & r_we;
  assign s_rd  = s_en & ~s_we;
  assign r_rd  = r_en & ~r_we;

  // access handshake
  logic open_q, grant_q;
  dbm_access u_access (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (s_wr && (s_addr == A_OPEN)),
    .wr_val  (s_wdata[0]),
    .open_q  (open_q),
    .grant_q (grant_q)
  );

  // channels
  logic [NUM_CH-1:0][DATA_W-1:0] flags_all, hide_all, visible_all;
  logic [NUM_CH-1:0]             evt_st_all, evt_en_all;
  logic [NUM_CH-1:0]             set_strobe, clr_strobe;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CH; gi++) begin : g_ch
      logic s_sel, r_sel;
      assign s_sel = s_win && (s_idx == IDX_W'(gi));
      assign r_sel = r_win && (r_idx == IDX_W'(gi));
      assign set_strobe[gi] = s_wr && s_sel && (s_off == OFF_RAISE) && open_q;
      assign clr_strobe[gi] = r_wr && r_sel && (r_off == OFF_CLEAR);

      dbm_channel #(.HAS_EVT(HAS_EVT)) u_ch (
        .clk           (clk),
        .rst_n         (rst_n),
        .set_en        (set_strobe[gi]),
        .set_bits      (s_wdata),
        .clr_en        (clr_strobe[gi]),
        .clr_bits      (r_wdata),
        .hide_on_en    (r_wr && r_sel && (r_off == OFF_HIDE_ON)),
        .hide_on_bits  (r_wdata),
        .hide_off_en   (r_wr && r_sel && (r_off == OFF_HIDE_OFF)),
        .hide_off_bits (r_wdata),
        .evt_en_we     (s_wr && s_sel && (s_off == OFF_EVT_EN)),
        .evt_en_val    (s_wdata[0]),
        .evt_ack       (s_wr && s_sel && (s_off == OFF_EVT_ACK) && s_wdata[0]),
        .flags         (flags_all[gi]),
        .hide          (hide_all[gi]),
        .visible       (visible_all[gi]),
        .evt_st        (evt_st_all[gi]),
        .evt_en        (evt_en_all[gi])
      );
    end
  endgenerate

  assign rx_irq = |visible_all;

  // sending-port read mux
  word_t s_rd_nx;
  always_comb begin
    s_rd_nx = '0;
    if (s_win) begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (s_idx == IDX_W'(i)) begin
          case (s_off)
            OFF_FLAGS:  s_rd_nx = flags_all[i];
            OFF_EVT_ST: s_rd_nx = word_t'(evt_st_all[i]);
            OFF_EVT_EN: s_rd_nx = word_t'(evt_en_all[i]);
            default:    s_rd_nx = '0;
          endcase
        end
      end
    end else begin
      case (s_addr)
        A_COUNT: s_rd_nx = COUNT;
        A_OPEN:  s_rd_nx = word_t'(open_q);
        A_GRANT: s_rd_nx = word_t'(grant_q);
        A_ARCH:  s_rd_nx = ARCH_ID;
        default: s_rd_nx = '0;
      endcase
    end
  end

  // receiving-port read mux
  word_t r_rd_nx;
  always_comb begin
    r_rd_nx = '0;
    if (r_win) begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (r_idx == IDX_W'(i)) begin
          case (r_off)
            OFF_FLAGS:   r_rd_nx = flags_all[i];
            OFF_VISIBLE: r_rd_nx = visible_all[i];
            OFF_HIDE_ST: r_rd_nx = hide_all[i];
            default:     r_rd_nx = '0;
          endcase
        end
      end
    end else begin
      case (r_addr)
        A_COUNT: r_rd_nx = COUNT;
        A_ARCH:  r_rd_nx = ARCH_ID;
        default: r_rd_nx = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_rdata <= '0;
      r_rdata <= '0;
    end else begin
      s_rdata <= s_rd ? s_rd_nx : '0;
      r_rdata <= r_rd ? r_rd_nx : '0;
    end
  end

  AST_NO_SET_WITHOUT_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    !open_q |=> ((flags_all & ~$past(flags_all)) == '0));  // R4
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> (flags_all != '0));                         // R8
  AST_CLEAR_ONLY_FROM_RX: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_strobe == '0)) |=> ((~flags_all & $past(flags_all)) == '0)); // R6
endmodule

// File: tb/doorbell_mailbox_bench.sv
module doorbell_mailbox_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_en = 0, s_we = 0, r_en = 0, r_we = 0;
  logic [11:0] s_addr = '0, r_addr = '0;
  logic [31:0] s_wdata = '0, r_wdata = '0;
  logic [31:0] s_rdata, r_rdata;
  logic rx_irq;
  logic x_en = 0, x_we = 0;
  logic [11:0] x_addr = '0;
  logic [31:0] x_wdata = '0;
  logic [31:0] x_rdata, x_rrdata;
  logic x_irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  doorbell_mailbox #(.NUM_CH(4), .MINOR_REV(1)) u_doorbell_mailbox (
    .clk(clk), .rst_n(rst_n),
    .s_en(s_en), .s_we(s_we), .s_addr(s_addr), .s_wdata(s_wdata), .s_rdata(s_rdata),
    .r_en(r_en), .r_we(r_we), .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata),
    .rx_irq(rx_irq));

  doorbell_mailbox #(.NUM_CH(3), .MINOR_REV(0)) u_doorbell_mailbox_r0 (
    .clk(clk), .rst_n(rst_n),
    .s_en(x_en), .s_we(x_we), .s_addr(x_addr), .s_wdata(x_wdata), .s_rdata(x_rdata),
    .r_en(1'b0), .r_we(1'b0), .r_addr(12'h000), .r_wdata(32'h0), .r_rdata(x_rrdata),
    .rx_irq(x_irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic s_wr(input logic [11:0] a, input logic [31:0] d);
    s_en = 1; s_we = 1; s_addr = a; s_wdata = d;
    @(negedge clk);
    s_en = 0; s_we = 0;
  endtask
  task automatic s_rd(input logic [11:0] a, output logic [31:0] d);
    s_en = 1; s_we = 0; s_addr = a;
    @(negedge clk);
    s_en = 0; d = s_rdata;
  endtask
  task automatic r_wr(input logic [11:0] a, input logic [31:0] d);
    r_en = 1; r_we = 1; r_addr = a; r_wdata = d;
    @(negedge clk);
    r_en = 0; r_we = 0;
  endtask
  task automatic r_rd(input logic [11:0] a, output logic [31:0] d);
    r_en = 1; r_we = 0; r_addr = a;
    @(negedge clk);
    r_en = 0; d = r_rdata;
  endtask
  task automatic x_wr(input logic [11:0] a, input logic [31:0] d);
    x_en = 1; x_we = 1; x_addr = a; x_wdata = d;
    @(negedge clk);
    x_en = 0; x_we = 0;
  endtask
  task automatic x_rd(input logic [11:0] a, output logic [31:0] d);
    x_en = 1; x_we = 0; x_addr = a;
    @(negedge clk);
    x_en = 0; d = x_rdata;
  endtask

  function automatic logic [11:0] win(input int c, input int off);
    return 12'(c * 32 + off);
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] m_st [4];
    logic [31:0] m_mk [4];
    logic        exp_irq;
    for (int c = 0; c < 4; c++) begin m_st[c] = '0; m_mk[c] = '0; end

    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state
    chk("R1 irq", {31'b0, rx_irq}, 32'h0);
    chk("R1 rdata", s_rdata, 32'h0);
    for (int c = 0; c < 4; c++) begin
      s_rd(win(c, 0), d); chk("R1 flags", d, 32'h0);
      r_rd(win(c, 16), d); chk("R1 mask", d, 32'h0);
    end
    s_rd(12'hF88, d); chk("R1 request", d, 32'h0);
    s_rd(12'hF8C, d); chk("R1 grant", d, 32'h0);

    // R9: configuration and identification
    s_rd(12'hF80, d); chk("R9 s count", d, 32'd4);
    r_rd(12'hF80, d); chk("R9 r count", d, 32'd4);
    s_rd(12'hFCC, d); chk("R9 s arch", d, 32'h10 + 32'd1);
    r_rd(12'hFCC, d); chk("R9 r arch", d, 32'h10 + 32'd1);
    x_rd(12'hF80, d); chk("R9 rev0 count", d, 32'd3);
    x_rd(12'hFCC, d); chk("R9 rev0 arch", d, 32'h10);

    // R4: set without an open request is ignored
    s_wr(win(0, 12), 32'hFFFF_FFFF);
    s_rd(win(0, 0), d); chk("R4 closed set", d, 32'h0);
    chk("R4 irq", {31'b0, rx_irq}, 32'h0);

    // R5: request / grant timing (reads sample grant one edge later)
    s_wr(12'hF88, 32'h1);
    s_rd(12'hF8C, d); chk("R5 grant +1", d, 32'h0);
    s_rd(12'hF8C, d); chk("R5 grant +2", d, 32'h0);
    s_rd(12'hF8C, d); chk("R5 grant +3", d, 32'h1);
    s_rd(12'hF88, d); chk("R5 request", d, 32'h1);

    // R3 / R6: set sweep, both views
    for (int c = 0; c < 4; c++) begin
      logic [31:0] pa, pb;
      pa = 32'h1 << (c * 5);
      pb = 32'h8000_0000 >> c;
      s_wr(win(c, 12), pa);
      s_wr(win(c, 12), pb);
      s_wr(win(c, 12), 32'h0);
      m_st[c] = m_st[c] | pa | pb;
      s_rd(win(c, 0), d); chk("R3 sender flags", d, m_st[c]);
      r_rd(win(c, 0), d); chk("R6 receiver flags", d, m_st[c]);
    end
    chk("R8 irq pending", {31'b0, rx_irq}, 32'h1);

    // R7: mask sweep
    for (int c = 0; c < 4; c++) begin
      logic [31:0] mk;
      mk = 32'h0000_FFFF << (c * 4);
      r_wr(win(c, 20), mk);
      m_mk[c] = m_mk[c] | mk;
      r_wr(win(c, 24), 32'h0000_00F0);
      m_mk[c] = m_mk[c] & ~32'h0000_00F0;
      r_rd(win(c, 16), d); chk("R7 mask", d, m_mk[c]);
      r_rd(win(c, 4), d);  chk("R7 visible", d, m_st[c] & ~m_mk[c]);
    end

    // R8: fully masked, then one bit revealed
    for (int c = 0; c < 4; c++) begin
      r_wr(win(c, 20), 32'hFFFF_FFFF);
      m_mk[c] = 32'hFFFF_FFFF;
    end
    chk("R8 all masked", {31'b0, rx_irq}, 32'h0);
    r_wr(win(2, 24), 32'h2000_0000);
    m_mk[2] = m_mk[2] & ~32'h2000_0000;
    exp_irq = 1'b0;
    for (int c = 0; c < 4; c++) exp_irq = exp_irq | (|(m_st[c] & ~m_mk[c]));
    chk("R8 revealed", {31'b0, rx_irq}, {31'b0, exp_irq});

    // R6: partial clear then clear all
    r_wr(win(1, 8), 32'h0000_0020);
    m_st[1] = m_st[1] & ~32'h0000_0020;
    r_rd(win(1, 0), d); chk("R6 partial clear", d, m_st[1]);
    r_wr(win(1, 8), 32'hFFFF_FFFF);
    m_st[1] = '0;
    s_rd(win(1, 0), d); chk("R6 clear all", d, 32'h0);

    // R6: set and clear on the same cycle, set wins
    s_en = 1; s_we = 1; s_addr = win(3, 12); s_wdata = 32'h0000_0006;
    r_en = 1; r_we = 1; r_addr = win(3, 8);  r_wdata = 32'h1000_0006;
    @(negedge clk);
    s_en = 0; s_we = 0; r_en = 0; r_we = 0;
    m_st[3] = (m_st[3] & ~32'h1000_0006) | 32'h0000_0006;
    r_rd(win(3, 0), d); chk("R6 set beats clear", d, m_st[3]);

    // R2: reserved and unmapped addresses
    s_rd(win(0, 4), d);  chk("R2 s reserved offset", d, 32'h0);
    r_rd(win(0, 12), d); chk("R2 r reserved offset", d, 32'h0);
    s_rd(win(4, 0), d);  chk("R2 s index beyond", d, 32'h0);
    r_rd(win(4, 0), d);  chk("R2 r index beyond", d, 32'h0);
    r_wr(win(0, 12), 32'hFFFF_FFFF);
    r_wr(12'hF90, 32'hFFFF_FFFF);
    s_wr(12'hF90, 32'hFFFF_FFFF);
    s_wr(win(4, 12), 32'hFFFF_FFFF);
    r_rd(win(0, 0), d);  chk("R2 write ignored", d, m_st[0]);
    s_rd(12'hF90, d);    chk("R2 unused frame addr", d, 32'h0);

    // R10: sender event on drain
    s_wr(win(1, 24), 32'h1);
    s_rd(win(1, 24), d); chk("R10 enable", d, 32'h1);
    s_wr(win(1, 12), 32'h5);
    r_wr(win(1, 8), 32'h1);
    s_rd(win(1, 16), d); chk("R10 no event on partial", d, 32'h0);
    r_wr(win(1, 8), 32'hFFFF_FFFF);
    s_rd(win(1, 16), d); chk("R10 event on drain", d, 32'h1);
    s_wr(win(1, 20), 32'h1);
    s_rd(win(1, 16), d); chk("R10 ack", d, 32'h0);
    r_wr(win(0, 8), 32'hFFFF_FFFF);
    m_st[0] = '0;
    s_rd(win(0, 16), d); chk("R10 disabled channel", d, 32'h0);
    x_wr(12'h018, 32'h1);
    x_rd(12'h018, d);    chk("R10 rev0 enable", d, 32'h0);
    x_rd(12'h010, d);    chk("R10 rev0 status", d, 32'h0);

    // R5 / R4: closing the transfer
    s_wr(12'hF88, 32'h0);
    s_rd(12'hF8C, d); chk("R5 grant drops", d, 32'h0);
    s_rd(12'hF88, d); chk("R5 request drops", d, 32'h0);
    s_wr(win(0, 12), 32'h1);
    s_rd(win(0, 0), d); chk("R4 set after close", d, 32'h0);

    done = 1;
    finish_run();
  end
endmodule